// File: doc/BRIEF.md
# Transmit DMA Request Controller

This block decides when a transmit channel asks the system DMA engine for more frame data. It watches how many bytes sit in a 32-entry transmit FIFO, raises a request for a burst whose size depends on the mode and on the bytes still owed, and counts each acknowledged byte. In counted mode a 12-bit byte count sets the frame length. When the last byte has been moved, the block sends a one-cycle frame-end strobe to the transmitter so that the CRC can follow.

In continuous mode the byte count plays no part. A 32-byte burst is requested each time the FIFO is completely empty, which allows frames of any length. If software clears the continuous bit while a frame is running, counting restarts from zero and exactly the programmed number of further bytes are fetched. If the transmitter wants a byte while the FIFO is empty, the block stops requesting and drives an idle-fill level. The transmitter then sends ones where the CRC would have gone. That state lasts until a transmit reset.

Top module: `tx_dma_req_ctrl`

## Requirements
- R1: After `rst`, `dma_req_o`, `busy_o`, `idle_fill_o`, `frame_end_o` and `underrun_o` are all 0. A `start_i` pulse while neither busy nor in idle-fill sets `busy_o` from the next cycle.
- R2: In counted mode (`cont_i`=0), a burst of N = min(32, bytes still owed) is opened only when the free space (32 minus `fifo_level_i`, the number of bytes held) is at least N. `dma_req_o` rises in the cycle after that condition holds and stays high until N acknowledges have been accepted.
- R3: In continuous mode (`cont_i`=1), a burst of 32 is opened only when `fifo_level_i` is 0. The byte count has no effect, so more than `bcount_i` bytes are moved.
- R4: A counted frame moves exactly `bcount_i` bytes, where a value of 0 stands for 4096. `bcount_i` is held stable during the frame.
- R5: `frame_end_o` is a one-cycle pulse in the cycle after the final acknowledge is accepted. `busy_o` and `dma_req_o` are 0 in that same cycle.
- R6: When `cont_i` falls while busy, the byte counter restarts at zero in that cycle. An acknowledge accepted in that cycle counts as the first byte. Exactly `bcount_i` bytes are then moved before `frame_end_o`.
- R7: When the block is busy, `tx_take_i` is 1 and `fifo_level_i` is 0, the next cycle shows a one-cycle `underrun_o` pulse, `idle_fill_o`=1, `busy_o`=0 and `dma_req_o`=0. No frame-end pulse occurs.
- R8: `idle_fill_o` stays 1 until `xres_i`, and `start_i` has no effect while it is set.
- R9: `dma_ack_i` is ignored in any cycle where `dma_req_o` is 0.
- R10: `start_i` is ignored while busy: the running frame keeps its count.
- R11: `xres_i` returns the block to the reset state of R1 in the next cycle, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xres_i | input | 1 | Transmit reset command |
| start_i | input | 1 | Start-of-frame command pulse |
| cont_i | input | 1 | Continuous-transmit mode bit |
| bcount_i | input | 12 | Frame byte count (0 means 4096) |
| fifo_level_i | input | 6 | Bytes currently held in the transmit FIFO |
| tx_take_i | input | 1 | Transmitter wants a byte this cycle |
| dma_ack_i | input | 1 | DMA acknowledge, one byte per accepted cycle |
| dma_req_o | output | 1 | DMA request |
| busy_o | output | 1 | Frame in progress |
| frame_end_o | output | 1 | Last counted byte delivered; append CRC |
| underrun_o | output | 1 | Underrun detected (pulse) |
| idle_fill_o | output | 1 | Transmitter sends ones instead of CRC |

## Verification
The hardest case to reach is clearing the continuous bit while a 32-byte burst is half done. The bench has to land on that cycle with acknowledges still arriving, and then show that exactly the programmed count follows. It gets there by running a continuous frame for a few hundred cycles with alternating acknowledges and a transmitter that drains the FIFO every third cycle, then dropping the bit at an arbitrary cycle. Underrun is reached by letting the FIFO partly fill and then switching the transmitter to take a byte every cycle, which outpaces the DMA refills.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tx_state_e;

    // Events raised in one cycle, already qualified by priority
    typedef struct packed {
        logic done;
        logic under;
    } tx_evt_t;

endpackage

// File: rtl/tx_dma_fsm.sv
module tx_dma_fsm
    import tx_dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xres,
    input  logic      start,
    input  tx_evt_t   evt,
    output tx_state_e state
);

    tx_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start) state_n = ST_RUN;
            ST_RUN: begin
                if (evt.under)     state_n = ST_HALT;
                else if (evt.done) state_n = ST_IDLE;
            end
            ST_HALT: state_n = ST_HALT;
            default: state_n = ST_IDLE;
        endcase
        if (xres) state_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

endmodule

// File: rtl/tx_dma_count.sv
module tx_dma_count #(
    parameter int CNT_W = 12,
    localparam int TW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             cont,
    input  logic             cont_fall,
    input  logic             ack,
    input  logic [CNT_W-1:0] bcount,
    output logic [TW-1:0]    remain,
    output logic             done
);

    logic [TW-1:0] sent;
    logic [TW-1:0] base;
    logic [TW-1:0] total;

    // A zero count stands for the full 2^CNT_W bytes
    assign total  = (bcount == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, bcount};
    assign base   = cont_fall ? '0 : sent;
    assign remain = total - base;
    assign done   = run & ~cont & ack & (remain == TW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) sent <= '0;
        else if (run)   sent <= base + {{(TW-1){1'b0}}, ack};
    end

endmodule

// File: rtl/tx_dma_burst.sv
module tx_dma_burst #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 12,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             cont,
    input  logic [LVL_W-1:0] level,
    input  logic [CNT_W:0]   remain,
    input  logic             ack,
    input  logic             done,
    input  logic             under,
    output logic             req
);

    localparam logic [LVL_W-1:0] FULL   = LVL_W'(DEPTH);
    localparam logic [CNT_W:0]   FULL_W = (CNT_W + 1)'(DEPTH);

    logic [LVL_W-1:0] left;
    logic [LVL_W-1:0] need;
    logic [LVL_W-1:0] room;
    logic             open;

    assign room = FULL - level;
    assign need = (cont || remain >= FULL_W) ? FULL : LVL_W'(remain);
    assign open = run & (left == '0) & ~under & (room >= need);

    always_ff @(posedge clk) begin
        if (rst || clr || under || done) left <= '0;
        else if (ack)                    left <= left - LVL_W'(1);
        else if (open)                   left <= need;
    end

    assign req = (left != '0);

endmodule

// File: rtl/tx_dma_req_ctrl.sv
module tx_dma_req_ctrl
    import tx_dma_pkg::*;
#(
    parameter int  FIFO_DEPTH = 32,
    parameter int  CNT_W      = 12,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xres_i,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] bcount_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    input  logic             tx_take_i,
    input  logic             dma_ack_i,
    output logic             dma_req_o,
    output logic             busy_o,
    output logic             frame_end_o,
    output logic             underrun_o,
    output logic             idle_fill_o
);

    tx_state_e      state;
    tx_evt_t        evt;
    logic           cont_q;
    logic           run;
    logic           ack_acc;
    logic           cont_fall;
    logic           done_raw;
    logic           clr_cnt;
    logic [CNT_W:0] remain;
    logic           fend_q;
    logic           under_q;

    assign run       = (state == ST_RUN);
    assign ack_acc   = dma_ack_i & dma_req_o;
    assign cont_fall = run & cont_q & ~cont_i;
    assign clr_cnt   = xres_i | ((state == ST_IDLE) & start_i);

    // Underrun outranks a coincident final byte; transmit reset outranks both
    assign evt.under = run & tx_take_i & (fifo_level_i == '0) & ~xres_i;
    assign evt.done  = done_raw & ~evt.under & ~xres_i;

    tx_dma_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .xres  (xres_i),
        .start (start_i),
        .evt   (evt),
        .state (state)
    );

    tx_dma_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_cnt),
        .run       (run),
        .cont      (cont_i),
        .cont_fall (cont_fall),
        .ack       (ack_acc),
        .bcount    (bcount_i),
        .remain    (remain),
        .done      (done_raw)
    );

    tx_dma_burst #(
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W),
        .LVL_W (LVL_W)
    ) u_burst (
        .clk    (clk),
        .rst    (rst),
        .clr    (xres_i),
        .run    (run),
        .cont   (cont_i),
        .level  (fifo_level_i),
        .remain (remain),
        .ack    (ack_acc),
        .done   (evt.done),
        .under  (evt.under),
        .req    (dma_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_q  <= 1'b0;
            fend_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            cont_q  <= cont_i;
            fend_q  <= evt.done;
            under_q <= evt.under;
        end
    end

    assign busy_o      = run;
    assign idle_fill_o = (state == ST_HALT);
    assign frame_end_o = fend_q;
    assign underrun_o  = under_q;

endmodule

// File: rtl/tx_dma_req_chk.sv
module tx_dma_req_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             xres_i,
    input logic             cont_i,
    input logic [LVL_W-1:0] fifo_level_i,
    input logic             dma_ack_i,
    input logic             dma_req_o,
    input logic             busy_o,
    input logic             frame_end_o,
    input logic             underrun_o,
    input logic             idle_fill_o
);

    AST_REQ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> busy_o); // R2

    AST_CONT_BURST_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req_o) && $past(cont_i) |-> $past(fifo_level_i) == '0); // R3

    AST_FEND_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |-> $past(dma_ack_i && dma_req_o) && !busy_o && !dma_req_o); // R5

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(frame_end_o && underrun_o)); // R7

    AST_UNDERRUN_TO_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> idle_fill_o && !busy_o && !dma_req_o); // R7

    AST_IDLE_FILL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        idle_fill_o && !xres_i |=> idle_fill_o); // R8

    AST_XRES_CLEARS: assert property (@(posedge clk) disable iff (rst)
        xres_i |=> !busy_o && !dma_req_o && !idle_fill_o); // R11

endmodule

bind tx_dma_req_ctrl tx_dma_req_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_tx_dma_req_ctrl.sv
module sim_tx_dma_req_ctrl;

    localparam int DEPTH = 32;
    localparam int CW    = 12;
    localparam int LW    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xres = 1'b0;
    logic          start = 1'b0;
    logic          cont = 1'b0;
    logic          take = 1'b0;
    logic          ack = 1'b0;
    logic [CW-1:0] bcount = '0;
    logic [LW-1:0] fifo_level = '0;
    logic          dma_req, busy, frame_end, underrun, idle_fill;

    always #5 clk = ~clk;

    tx_dma_req_ctrl u0 (
        .clk(clk), .rst(rst), .xres_i(xres), .start_i(start), .cont_i(cont),
        .bcount_i(bcount), .fifo_level_i(fifo_level), .tx_take_i(take),
        .dma_ack_i(ack), .dma_req_o(dma_req), .busy_o(busy),
        .frame_end_o(frame_end), .underrun_o(underrun), .idle_fill_o(idle_fill)
    );

    int checks = 0, fails = 0;
    int ack_mode = 0, take_mode = 0, phase = 0;
    int lvl = 0, nacc = 0, fe_bytes = 0;
    bit fe_seen = 0, ur_seen = 0;
    // reference model state
    int m_st = 0, m_sent = 0, m_burst = 0;
    bit m_fe = 0, m_ur = 0, m_contq = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // stimulus for acknowledge, transmitter and FIFO level
    always @(negedge clk) begin
        phase++;
        fifo_level = LW'(lvl);
        case (ack_mode)
            0: ack = 1'b0;
            1: ack = 1'b1;
            default: ack = (phase % 2 == 0);
        endcase
        case (take_mode)
            0: take = 1'b0;
            1: take = 1'b1;
            default: take = (phase % 3 == 0) && (lvl > 0);
        endcase
    end

    // behavioural reference, advanced on each edge
    always @(posedge clk) begin
        int tot, need;
        bit acc;
        acc = ack && (m_burst > 0);
        tot = (bcount == 0) ? 4096 : int'(bcount);
        if (rst || xres) lvl = 0;
        else begin
            if (acc) lvl++;
            if (take && lvl > 0) lvl--;
        end
        if (acc) nacc++;
        m_fe = 0;
        m_ur = 0;
        if (rst || xres) begin
            m_st = 0; m_sent = 0; m_burst = 0;
        end else if (m_st == 0) begin
            if (start) begin m_st = 1; m_sent = 0; end
        end else if (m_st == 1) begin
            if (m_contq && !cont) m_sent = 0;
            if (take && fifo_level == 0) begin
                m_st = 2; m_burst = 0; m_ur = 1;
            end else if (acc && !cont && m_sent + 1 == tot) begin
                m_st = 0; m_burst = 0; m_fe = 1;
            end else if (acc) begin
                m_sent++; m_burst--;
            end else if (m_burst == 0) begin
                need = cont ? DEPTH : ((tot - m_sent) < DEPTH ? tot - m_sent : DEPTH);
                if (DEPTH - int'(fifo_level) >= need) m_burst = need;
            end
        end
        m_contq = rst ? 1'b0 : cont;
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #3;
        check(dma_req == (m_burst > 0), "R2/R3 dma_req", dma_req, m_burst > 0);
        check(busy == (m_st == 1), "R1 busy", busy, m_st == 1);
        check(idle_fill == (m_st == 2), "R8 idle_fill", idle_fill, m_st == 2);
        check(frame_end == m_fe, "R5 frame_end", frame_end, m_fe);
        check(underrun == m_ur, "R7 underrun", underrun, m_ur);
        if (frame_end) begin fe_seen = 1; fe_bytes = nacc; end
        if (underrun) ur_seen = 1;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_xres();
        @(negedge clk) xres = 1'b1;
        @(negedge clk) xres = 1'b0;
    endtask

    task automatic wait_frame(int limit);
        for (int i = 0; i < limit && !fe_seen; i++) @(negedge clk);
    endtask

    task automatic drain();
        take_mode = 2; ack_mode = 0;
        for (int i = 0; i < 400 && lvl > 0; i++) @(negedge clk);
    endtask

    task automatic counted(int n, int am, int tm, string tag);
        @(negedge clk);
        cont = 0; bcount = CW'(n); ack_mode = am; take_mode = tm;
        nacc = 0; fe_seen = 0;
        pulse_start();
        wait_frame(60000);
        check(fe_seen && fe_bytes == ((n == 0) ? 4096 : n), tag, fe_bytes, (n == 0) ? 4096 : n);
        drain();
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(!dma_req && !busy && !idle_fill && !frame_end && !underrun, "R1 reset state", busy, 0);

        // R4 R9: short frame, acknowledge held high even without request
        counted(5, 1, 0, "R4 R9 bytes in 5-byte frame");
        // R2: multi-burst counted frame with draining
        counted(70, 2, 2, "R2 R4 bytes in 70-byte frame");
        // R4: zero count means 4096
        counted(0, 1, 2, "R4 bytes in zero-count frame");

        // R10: second start while busy is ignored
        @(negedge clk);
        bcount = CW'(40); ack_mode = 0; take_mode = 2; nacc = 0; fe_seen = 0;
        pulse_start();
        repeat (6) @(negedge clk);
        bcount = CW'(40);
        pulse_start();
        check(busy == 1, "R10 busy after extra start", busy, 1);
        ack_mode = 2;
        wait_frame(2000);
        check(fe_seen && fe_bytes == 40, "R10 bytes after extra start", fe_bytes, 40);
        drain();

        // R3 R6: continuous frame, then clear the bit mid-stream
        @(negedge clk);
        cont = 1; bcount = CW'(3); ack_mode = 2; take_mode = 2; nacc = 0; fe_seen = 0;
        pulse_start();
        repeat (300) @(negedge clk);
        check(nacc > 3 && busy && !fe_seen, "R3 continuous ignores count", nacc, 4);
        cont = 0; nacc = 0; fe_seen = 0;
        wait_frame(2000);
        check(fe_seen && fe_bytes == 3, "R6 bytes after clearing continuous", fe_bytes, 3);
        drain();

        // R7 R8 R11: underrun in continuous mode
        @(negedge clk);
        cont = 1; ack_mode = 2; take_mode = 0; ur_seen = 0;
        pulse_start();
        for (int i = 0; i < 200 && lvl < 10; i++) @(negedge clk);
        take_mode = 1;
        for (int i = 0; i < 200 && !ur_seen; i++) @(negedge clk);
        check(ur_seen, "R7 underrun observed", ur_seen, 1);
        check(idle_fill && !busy && !dma_req, "R7 idle fill after underrun", idle_fill, 1);
        take_mode = 0;
        pulse_start();
        repeat (4) @(negedge clk);
        check(idle_fill && !busy && !dma_req, "R8 start ignored in idle fill", busy, 0);
        cont = 0;
        pulse_xres();
        check(!idle_fill && !busy && !dma_req, "R11 reset leaves idle fill", idle_fill, 0);

        // R11: reset in the middle of a counted frame
        @(negedge clk);
        bcount = CW'(100); ack_mode = 2; take_mode = 2; fe_seen = 0;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_xres();
        check(!busy && !dma_req && !frame_end, "R11 reset mid frame", busy, 0);
        // R1: fresh frame after reset
        counted(7, 2, 2, "R1 R4 bytes after reset");

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule